// File: doc/BRIEF.md
# Bidirectional Port with Latch-Mismatch Interrupt

An eight-pin general-purpose I/O port for a microcontroller-style core. Software sets each pin's direction, drives output pins from a data latch, and reads back the levels seen at the pins. Those levels pass through a synchronizer first. One shared active-low control bit turns on weak pull-ups for every pin that is configured as an input.

The port raises an interrupt flag whenever an input pin's synchronized level differs from that pin's bit in the data latch. It does not compare against an earlier sample of the pins. Pins configured as outputs take no part in the comparison. The flag is set again on every cycle in which any mismatch remains. To clear it, software reads the port, writes the value it read back into the latch, and then clears the flag.

A wake request output combines the flag with a purely combinational comparison of the raw pins. A change on an input pin can therefore request wake-up while the clock is stopped.

Top module: `gpio_mismatch_port`

## Requirements
- R1: Direction bit value 1 makes a pin an input (`pin_oe` bit 0). Value 0 makes it an output (`pin_oe` bit 1) that drives `pin_out` from the data latch. A `dir_wr` strobe loads `dir_wdata`, and the new value takes effect after the clock edge.
- R2: A `data_wr` strobe loads `data_wdata` into the output latch, which appears on `pin_out` after the clock edge. Writing the latch does not change what a read returns.
- R3: A `data_rd` strobe captures the pin levels after a two-flop synchronizer into `data_rdata`, which holds that value until the next `data_rd`.
- R4: `pin_pu` bit i is 1 only when the shared pull-up control bit is 0 and pin i is an input. `pu_wr` loads `pu_wdata` into that control bit.
- R5: An output pin whose level differs from its latch bit never sets the interrupt flag.
- R6: If any input pin's synchronized level differs from its latch bit, `irq_flag` is 1 after the next clock edge.
- R7: `irq_clr` drops the flag after the clock edge only when no mismatch exists in that cycle. If a mismatch is present in the same cycle, the set takes priority.
- R8: After a port read, a write of the value that was read, and then a clear, the flag stays at 0 while the pins hold still.
- R9: `wake_req` is 1 whenever the flag is 1 or any input pin's raw, unsynchronized level differs from its latch bit. This path needs no clock edge.
- R10: A `dir_rd` strobe captures the direction register into `dir_rdata`.
- R11: Reset is asynchronous and active low. It sets direction to all ones and clears the latch, the pull-up control bit (pull-ups on), the flag and the read holding registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Write strobe for the output latch |
| data_wdata | input | 8 | Value written to the output latch |
| data_rd | input | 1 | Read strobe for the pin levels |
| data_rdata | output | 8 | Captured synchronized pin levels |
| dir_wr | input | 1 | Write strobe for the direction register |
| dir_wdata | input | 8 | Direction value, 1 means input |
| dir_rd | input | 1 | Read strobe for the direction register |
| dir_rdata | output | 8 | Captured direction register |
| pu_wr | input | 1 | Write strobe for the pull-up control bit |
| pu_wdata | input | 1 | Pull-up control, 0 enables pull-ups |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output drive values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad weak pull-up enables |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| wake_req | output | 1 | Wake request, usable with the clock stopped |

## Verification
The clear strobe and a persisting mismatch can land in the same cycle. The bench provokes this by pulsing `irq_clr` while an input pin still differs from the latch, and by random clears mixed with random pin, latch and direction changes. A behavioural reference model decides the expected flag with the set taking priority, and compares it every cycle. A latch write can also remove a mismatch in the same cycle as a clear; the model resolves this from the values held before that edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned GPIO_WIDTH_DEF  = 8;
    localparam int unsigned GPIO_SYNC_DEF   = 2;

    typedef enum logic [1:0] {
        IRQ_HOLD  = 2'd0,
        IRQ_SET   = 2'd1,
        IRQ_CLEAR = 2'd2
    } irq_cause_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = gpio_pkg::GPIO_WIDTH_DEF,
    parameter int unsigned STAGES = gpio_pkg::GPIO_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_comb begin
        pipe_d[0] = async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_out = pipe_q[LAST];

    // R3: the last stage shows the first stage's value one cycle later
    if (STAGES > 1) begin : g_chk
        assert_sync_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (pipe_q[1] == $past(pipe_q[0])));
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int unsigned WIDTH = gpio_pkg::GPIO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [WIDTH-1:0] data_wdata,
    input  logic             data_rd,
    input  logic             dir_wr,
    input  logic [WIDTH-1:0] dir_wdata,
    input  logic             dir_rd,
    input  logic             pu_wr,
    input  logic             pu_wdata,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q,
    output logic             pu_off_q,
    output logic [WIDTH-1:0] data_rdata,
    output logic [WIDTH-1:0] dir_rdata
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
        logic             pu_off;
        logic [WIDTH-1:0] rd_pins;
        logic [WIDTH-1:0] rd_dir;
    } regs_t;

    localparam regs_t REGS_RST = '{
        dir:     '1,
        lat:     '0,
        pu_off:  1'b0,
        rd_pins: '0,
        rd_dir:  '0
    };

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dir_wr)  st_d.dir     = dir_wdata;
        if (data_wr) st_d.lat     = data_wdata;
        if (pu_wr)   st_d.pu_off  = pu_wdata;
        if (data_rd) st_d.rd_pins = pins_sync;
        if (dir_rd)  st_d.rd_dir  = st_q.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REGS_RST;
        else        st_q <= st_d;
    end

    assign dir_q      = st_q.dir;
    assign lat_q      = st_q.lat;
    assign pu_off_q   = st_q.pu_off;
    assign data_rdata = st_q.rd_pins;
    assign dir_rdata  = st_q.rd_dir;

    assert_dir_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (dir_q == $past(dir_wdata)));
    assert_lat_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (lat_q == $past(data_wdata)));
    assert_rd_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> (data_rdata == $past(pins_sync)));
    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> $stable(data_rdata));
    assert_pu_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pu_wr |=> (pu_off_q == $past(pu_wdata)));
    assert_dir_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd |=> (dir_rdata == $past(dir_q)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int unsigned WIDTH = gpio_pkg::GPIO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic             pu_off_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = ~dir_q[i];
            pad_out[i] = lat_q[i];
            pad_pu[i]  = dir_q[i] & ~pu_off_q;
        end
    end

    // R4: no pin ever has a pull-up and an active driver together
    assert_pu_vs_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int unsigned WIDTH = gpio_pkg::GPIO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] pins_sync,
    input  logic [WIDTH-1:0] pins_raw,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic             wake_req
);
    import gpio_pkg::*;

    typedef struct packed {
        logic flag;
    } irq_t;

    irq_t             st_d, st_q;
    irq_cause_e       cause;
    logic [WIDTH-1:0] mism_vec;
    logic             mism_any;
    logic [WIDTH-1:0] raw_vec;

    always_comb begin
        mism_vec = dir_q & (pins_sync ^ lat_q);
        mism_any = |mism_vec;
        raw_vec  = dir_q & (pins_raw ^ lat_q);
        if (mism_any)     cause = IRQ_SET;
        else if (irq_clr) cause = IRQ_CLEAR;
        else              cause = IRQ_HOLD;
        st_d = st_q;
        unique case (cause)
            IRQ_SET:   st_d.flag = 1'b1;
            IRQ_CLEAR: st_d.flag = 1'b0;
            default:   st_d.flag = st_q.flag;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_flag = st_q.flag;
    assign wake_req = st_q.flag | (|raw_vec);

    assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mism_any |=> irq_flag);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !mism_any) |=> !irq_flag);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_clr && !mism_any) |=> $stable(irq_flag));
    assert_wake_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> wake_req);
endmodule

// File: rtl/gpio_mismatch_port.sv
module gpio_mismatch_port #(
    parameter int unsigned WIDTH  = gpio_pkg::GPIO_WIDTH_DEF,
    parameter int unsigned STAGES = gpio_pkg::GPIO_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [WIDTH-1:0] data_wdata,
    input  logic             data_rd,
    output logic [WIDTH-1:0] data_rdata,
    input  logic             dir_wr,
    input  logic [WIDTH-1:0] dir_wdata,
    input  logic             dir_rd,
    output logic [WIDTH-1:0] dir_rdata,
    input  logic             pu_wr,
    input  logic             pu_wdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic             wake_req
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;
    logic             pu_off_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .data_rd    (data_rd),
        .dir_wr     (dir_wr),
        .dir_wdata  (dir_wdata),
        .dir_rd     (dir_rd),
        .pu_wr      (pu_wr),
        .pu_wdata   (pu_wdata),
        .pins_sync  (pins_sync),
        .dir_q      (dir_q),
        .lat_q      (lat_q),
        .pu_off_q   (pu_off_q),
        .data_rdata (data_rdata),
        .dir_rdata  (dir_rdata)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_q    (dir_q),
        .lat_q    (lat_q),
        .pu_off_q (pu_off_q),
        .pad_out  (pin_out),
        .pad_oe   (pin_oe),
        .pad_pu   (pin_pu)
    );

    gpio_irq #(.WIDTH(WIDTH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .pins_sync (pins_sync),
        .pins_raw  (pin_in),
        .irq_clr   (irq_clr),
        .irq_flag  (irq_flag),
        .wake_req  (wake_req)
    );

    // R5: a mismatch confined to output pins never raises the flag
    assert_out_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag && ((dir_q & (pins_sync ^ lat_q)) == '0)) |=> !irq_flag);
endmodule

// File: tb/gpio_mismatch_port_bench.sv
module gpio_mismatch_port_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         data_wr = 0, data_rd = 0, dir_wr = 0, dir_rd = 0;
    logic         pu_wr = 0, pu_wdata = 0, irq_clr = 0;
    logic [W-1:0] data_wdata = '0, dir_wdata = '0, pin_in = '0;
    logic [W-1:0] data_rdata, dir_rdata, pin_out, pin_oe, pin_pu;
    logic         irq_flag, wake_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_mismatch_port u_gpio_mismatch_port (
        .clk(clk), .rst_n(rst_n),
        .data_wr(data_wr), .data_wdata(data_wdata), .data_rd(data_rd), .data_rdata(data_rdata),
        .dir_wr(dir_wr), .dir_wdata(dir_wdata), .dir_rd(dir_rd), .dir_rdata(dir_rdata),
        .pu_wr(pu_wr), .pu_wdata(pu_wdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .irq_clr(irq_clr), .irq_flag(irq_flag), .wake_req(wake_req)
    );

    // Behavioural reference model
    logic [W-1:0] pin_hist[$];
    logic [W-1:0] m_dir, m_lat, m_rd, m_dirrd;
    logic         m_puoff, m_flag;
    bit           m_live = 0;

    function automatic logic [W-1:0] sync_view();
        return (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : '0;
    endfunction

    function automatic bit any_diff(logic [W-1:0] dirv, logic [W-1:0] pins, logic [W-1:0] lat);
        int hits = 0;
        for (int b = 0; b < W; b++)
            if (dirv[b] && (pins[b] != lat[b])) hits++;
        return hits > 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pin_hist.delete();
            pin_hist.push_back('0);
            pin_hist.push_back('0);
            m_dir <= '1; m_lat <= '0; m_rd <= '0; m_dirrd <= '0;
            m_puoff <= 1'b0; m_flag <= 1'b0;
            m_live <= 1;
        end else begin
            logic [W-1:0] sv;
            sv = sync_view();
            if (any_diff(m_dir, sv, m_lat)) m_flag <= 1'b1;
            else if (irq_clr)               m_flag <= 1'b0;
            if (data_rd) m_rd    <= sv;
            if (dir_rd)  m_dirrd <= m_dir;
            if (dir_wr)  m_dir   <= dir_wdata;
            if (data_wr) m_lat   <= data_wdata;
            if (pu_wr)   m_puoff <= pu_wdata;
            pin_hist.push_back(pin_in);
            if (pin_hist.size() > 4) void'(pin_hist.pop_front());
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_live && rst_n) begin
            logic [W-1:0] pu_exp;
            for (int b = 0; b < W; b++) pu_exp[b] = m_dir[b] && !m_puoff;
            check("R1 pin_oe", pin_oe, ~m_dir);
            check("R2 pin_out", pin_out, m_lat);
            check("R3 data_rdata", data_rdata, m_rd);
            check("R4 pin_pu", pin_pu, pu_exp);
            check("R6 irq_flag", {7'd0, irq_flag}, {7'd0, m_flag});
            check("R9 wake_req", {7'd0, wake_req},
                  {7'd0, m_flag || any_diff(m_dir, pin_in, m_lat)});
            check("R10 dir_rdata", dir_rdata, m_dirrd);
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] got;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        check("R11 pin_oe", pin_oe, 8'h00);
        check("R11 pin_out", pin_out, 8'h00);
        check("R11 pin_pu", pin_pu, 8'hFF);
        check("R11 irq_flag", {7'd0, irq_flag}, 8'h00);
        dir_rd = 1; tick(); dir_rd = 0;
        check("R11 dir_rdata", dir_rdata, 8'hFF);

        // R4 pull-ups off, then on again
        pu_wr = 1; pu_wdata = 1; tick(); pu_wr = 0;
        check("R4 pull-ups off", pin_pu, 8'h00);
        pu_wr = 1; pu_wdata = 0; tick(); pu_wr = 0;

        // R1/R2 upper nibble outputs
        dir_wr = 1; dir_wdata = 8'h0F; tick(); dir_wr = 0;
        check("R1 oe", pin_oe, 8'hF0);
        check("R4 pu masked", pin_pu, 8'h0F);
        data_wr = 1; data_wdata = 8'h50; tick(); data_wr = 0;
        check("R2 drive", pin_out, 8'h50);

        // R5 output-pin disagreement is masked
        pin_in = 8'hA0; tick(4);
        check("R5 no flag", {7'd0, irq_flag}, 8'h00);
        check("R5 no wake", {7'd0, wake_req}, 8'h00);

        // R6/R9 input pin disagreement
        pin_in = 8'hA1;
        #1 check("R9 raw wake", {7'd0, wake_req}, 8'h01);
        tick(3);
        check("R6 flag set", {7'd0, irq_flag}, 8'h01);

        // R7 clear during mismatch: set wins
        irq_clr = 1; tick(); irq_clr = 0;
        check("R7 set wins", {7'd0, irq_flag}, 8'h01);

        // R8 read, write back, clear
        data_rd = 1; tick(); data_rd = 0;
        got = data_rdata;
        check("R3 read value", got, 8'hA1);
        data_wr = 1; data_wdata = got; tick(); data_wr = 0;
        tick();
        irq_clr = 1; tick(); irq_clr = 0;
        check("R8 cleared", {7'd0, irq_flag}, 8'h00);
        tick(3);
        check("R8 stays clear", {7'd0, irq_flag}, 8'h00);

        // R7 clear in the same cycle as a write that removes the mismatch
        pin_in = 8'hA3; tick(4);
        data_wr = 1; data_wdata = 8'hA3; irq_clr = 1; tick();
        data_wr = 0; irq_clr = 0;
        check("R7 set wins on write edge", {7'd0, irq_flag}, 8'h01);
        irq_clr = 1; tick(); irq_clr = 0;
        check("R7 clear", {7'd0, irq_flag}, 8'h00);

        // Random mix, reference model judges every cycle
        for (int i = 0; i < 3000; i++) begin
            data_wr    = ($urandom_range(0, 7) == 0);
            data_wdata = W'($urandom);
            data_rd    = ($urandom_range(0, 3) == 0);
            dir_wr     = ($urandom_range(0, 9) == 0);
            dir_wdata  = W'($urandom);
            dir_rd     = ($urandom_range(0, 3) == 0);
            pu_wr      = ($urandom_range(0, 15) == 0);
            pu_wdata   = 1'($urandom);
            irq_clr    = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 5) == 0) pin_in = W'($urandom);
            tick();
        end
        data_wr = 0; data_rd = 0; dir_wr = 0; dir_rd = 0; pu_wr = 0; irq_clr = 0;
        tick(3);
        finish_run();
    end
endmodule